// File: doc/BRIEF.md
# Stream Encoder Power-Up Sequencer

This block orders the bring-up and tear-down of a video stream encoder. Four commands (enable, unblank, blank, disable) each arrive as a one-cycle pulse. Each one starts a fixed list of steps. The steps drive the reset, enable and clock-enable lines of a symbol encoder, a pixel-to-symbol FIFO and a clock-ramp FIFO. Every reset is a two-phase handshake: the reset is raised, the block waits for the matching reset-done input to go high, the reset is dropped, and the block waits for reset-done to go low again. Blanking waits for the stream-status input to go low, which happens at vertical blank.

Each wait has a timeout. A prescaler turns the clock into poll intervals. If a reset-done wait is not satisfied within its poll budget, or the much longer status wait is not satisfied within its budget, the block gives up. It leaves its outputs where they are, sets a sticky error flag and goes back to idle. A sequence that completes raises a one-cycle done pulse.

The secondary-data enable is held high while video is enabled and at least one audio or generic packet enable is asserted. It drops when every packet enable is low, or when the blank step clears it.

Top module: `strm_enc_seq`

## Requirements
- R1: After reset, every control output, `busy`, `done` and `seq_err` are 0, and `pix_sel` is 0.
- R2: Enable runs these steps in order: `enc_clk_en` rises, `enc_rst` rises, the block waits for `enc_rst_done` high, `enc_rst` falls, the block waits for `enc_rst_done` low, then `enc_en` rises. `enc_en` never rises while `enc_rst` is high or `enc_clk_en` is low.
- R3: Unblank runs these steps in order:
  - load `pix_sel` with the `src_sel` value sampled with the command;
  - raise `vid_en`;
  - put the pixel FIFO through the two-phase reset and raise `pfifo_en`;
  - put the clock-ramp FIFO through the two-phase reset;
  - raise `crc_en`;
  - raise `cfifo_en` last.
- R4: Blank lowers `vid_en` first and then waits while `vid_status` is 1. Once `vid_status` is 0 it lowers `sdp_en`, `pfifo_en` and `cfifo_en` in that order, on consecutive cycles.
- R5: Disable lowers `enc_en`, and `enc_clk_en` falls on the next cycle.
- R6: A reset-done wait that is not satisfied after SHORT_POLLS intervals of SHORT_US microseconds stops the sequence, sets `seq_err` and drops `busy` without a `done` pulse. Outputs already driven stay as they are.
- R7: The blank status wait gives up after LONG_POLLS intervals of LONG_US microseconds, with the same stop behaviour as R6. The FIFO enables stay at their earlier values.
- R8: A command pulse that arrives while `busy` is 1 is ignored and never runs later.
- R9: `busy` is 1 from the cycle after an accepted command until the end of the sequence. A completed sequence gives exactly one one-cycle `done` pulse, with `busy` already 0.
- R10: `sdp_en` rises only when `vid_en` is 1 and some bit of `aud_pkt_en` or `gen_pkt_en` is 1. It falls only when all packet enables are 0, or at the blank step while `vid_en` is 0.
- R11: If several command pulses arrive together while idle, one is chosen by priority: disable, then blank, then unblank, then enable.
- R12: `seq_err` stays 1 until reset, and later commands still run normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_enable | input | 1 | Pulse: start the enable sequence |
| cmd_unblank | input | 1 | Pulse: start the unblank sequence |
| cmd_blank | input | 1 | Pulse: start the blank sequence |
| cmd_disable | input | 1 | Pulse: start the disable sequence |
| src_sel | input | SRC_W | Pixel source, sampled with an unblank command |
| enc_rst_done | input | 1 | Reset-done from the symbol encoder |
| pfifo_rst_done | input | 1 | Reset-done from the pixel-to-symbol FIFO |
| cfifo_rst_done | input | 1 | Reset-done from the clock-ramp FIFO |
| vid_status | input | 1 | Video transmission still active |
| aud_pkt_en | input | AUD_N | Audio packet enables |
| gen_pkt_en | input | GEN_N | Generic packet continuous-transmit enables |
| enc_clk_en | output | 1 | Encoder clock enable |
| enc_rst | output | 1 | Symbol encoder reset |
| enc_en | output | 1 | Symbol encoder enable (idle pattern) |
| pix_sel | output | SRC_W | Input mux pixel source |
| vid_en | output | 1 | Video stream enable |
| pfifo_rst | output | 1 | Pixel FIFO reset |
| pfifo_en | output | 1 | Pixel FIFO enable |
| cfifo_rst | output | 1 | Clock-ramp FIFO reset |
| cfifo_en | output | 1 | Clock-ramp FIFO enable |
| crc_en | output | 1 | Continuous CRC enable |
| sdp_en | output | 1 | Secondary-data path enable |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse when a sequence completes |
| seq_err | output | 1 | Sticky timeout flag |

## Verification
The bench builds the block with CLK_HZ set to 10 MHz, SHORT_US 1, SHORT_POLLS 10, LONG_US 10 and LONG_POLLS 20. With these values a reset-done timeout fires after about 100 cycles and a blank timeout after about 2000 cycles. Both abort paths can therefore be reached many times in a short run, which the default 50 ms status budget would not allow.

The reset-done lines are modelled as three-cycle echoes of the reset outputs, and each echo can be held stuck. The bench also holds `vid_status` high for a chosen time, so it controls when the blank sequence sees vertical blank.

// File: rtl/strm_enc_seq_pkg.sv
package strm_enc_seq_pkg;

   localparam int STEP_W = 4;

   typedef enum logic [1:0] {SEQ_ENABLE, SEQ_UNBLANK, SEQ_BLANK, SEQ_DISABLE} seq_t;
   typedef enum logic [2:0] {OP_SET, OP_CLR, OP_WAIT_HI, OP_WAIT_LO, OP_END} op_kind_t;
   typedef enum logic [3:0] {TG_CLK, TG_ENC_RST, TG_ENC_EN, TG_MUX, TG_VID, TG_PF_RST,
                             TG_PF_EN, TG_CF_RST, TG_CF_EN, TG_CRC, TG_SDP} tgt_t;
   typedef enum logic [1:0] {WS_ENC, WS_PF, WS_CF, WS_VID} wsrc_t;

   typedef struct packed {
      op_kind_t kind;
      tgt_t     tgt;
      wsrc_t    src;
   } op_t;

   function automatic op_t op_set(tgt_t t);
      return '{kind: OP_SET, tgt: t, src: WS_ENC};
   endfunction
   function automatic op_t op_clr(tgt_t t);
      return '{kind: OP_CLR, tgt: t, src: WS_ENC};
   endfunction
   function automatic op_t op_whi(wsrc_t w);
      return '{kind: OP_WAIT_HI, tgt: TG_CLK, src: w};
   endfunction
   function automatic op_t op_wlo(wsrc_t w);
      return '{kind: OP_WAIT_LO, tgt: TG_CLK, src: w};
   endfunction
   function automatic op_t op_end();
      return '{kind: OP_END, tgt: TG_CLK, src: WS_ENC};
   endfunction

   // Step program: one operation per step index for each sequence.
   function automatic op_t seq_op(seq_t s, logic [STEP_W-1:0] st);
      op_t o;
      o = op_end();
      case (s)
         SEQ_ENABLE:
            case (int'(st))
               0: o = op_set(TG_CLK);
               1: o = op_set(TG_ENC_RST);
               2: o = op_whi(WS_ENC);
               3: o = op_clr(TG_ENC_RST);
               4: o = op_wlo(WS_ENC);
               5: o = op_set(TG_ENC_EN);
               default: o = op_end();
            endcase
         SEQ_UNBLANK:
            case (int'(st))
               0:  o = op_set(TG_MUX);
               1:  o = op_set(TG_VID);
               2:  o = op_set(TG_PF_RST);
               3:  o = op_whi(WS_PF);
               4:  o = op_clr(TG_PF_RST);
               5:  o = op_wlo(WS_PF);
               6:  o = op_set(TG_PF_EN);
               7:  o = op_set(TG_CF_RST);
               8:  o = op_whi(WS_CF);
               9:  o = op_clr(TG_CF_RST);
               10: o = op_wlo(WS_CF);
               11: o = op_set(TG_CRC);
               12: o = op_set(TG_CF_EN);
               default: o = op_end();
            endcase
         SEQ_BLANK:
            case (int'(st))
               0: o = op_clr(TG_VID);
               1: o = op_wlo(WS_VID);
               2: o = op_clr(TG_SDP);
               3: o = op_clr(TG_PF_EN);
               4: o = op_clr(TG_CF_EN);
               default: o = op_end();
            endcase
         default:
            case (int'(st))
               0: o = op_clr(TG_ENC_EN);
               1: o = op_clr(TG_CLK);
               default: o = op_end();
            endcase
      endcase
      return o;
   endfunction

endpackage

// File: rtl/strm_enc_poll_timer.sv
module strm_enc_poll_timer #(
   parameter int DIV   = 200,
   parameter int POLLS = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   localparam int PW = $clog2(DIV + 1);
   localparam int CW = $clog2(POLLS + 1);

   if (DIV < 1 || POLLS < 1) begin : g_bad_cfg
      $error("strm_enc_poll_timer: DIV and POLLS must be at least 1");
   end

   logic          tick;
   logic [CW-1:0] cnt_q;

   if (DIV == 1) begin : g_direct
      assign tick = run;
   end else begin : g_prescale
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      pre_q <= '0;
         else if (!run)                   pre_q <= '0;
         else if (pre_q == PW'(DIV - 1))  pre_q <= '0;
         else                             pre_q <= pre_q + PW'(1);
      end
      assign tick = run && (pre_q == PW'(DIV - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              cnt_q <= '0;
      else if (!run)                           cnt_q <= '0;
      else if (tick && cnt_q != CW'(POLLS))    cnt_q <= cnt_q + CW'(1);
   end

   assign expired = (cnt_q == CW'(POLLS));
endmodule

// File: rtl/strm_enc_sdp_track.sv
module strm_enc_sdp_track #(
   parameter int AUD_N = 4,
   parameter int GEN_N = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             vid_on,
   input  logic             drop,
   input  logic [AUD_N-1:0] aud,
   input  logic [GEN_N-1:0] gen,
   output logic             sdp
);
   logic any_pkt;
   assign any_pkt = (|aud) || (|gen);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                sdp <= 1'b0;
      else if (drop || !any_pkt) sdp <= 1'b0;
      else if (vid_on)           sdp <= 1'b1;
   end
endmodule

// File: rtl/strm_enc_seq.sv
module strm_enc_seq
   import strm_enc_seq_pkg::*;
#(
   parameter int CLK_HZ      = 200_000_000,
   parameter int SHORT_US    = 1,
   parameter int SHORT_POLLS = 10,
   parameter int LONG_US     = 10,
   parameter int LONG_POLLS  = 5000,
   parameter int SRC_W       = 2,
   parameter int AUD_N       = 4,
   parameter int GEN_N       = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_enable,
   input  logic             cmd_unblank,
   input  logic             cmd_blank,
   input  logic             cmd_disable,
   input  logic [SRC_W-1:0] src_sel,
   input  logic             enc_rst_done,
   input  logic             pfifo_rst_done,
   input  logic             cfifo_rst_done,
   input  logic             vid_status,
   input  logic [AUD_N-1:0] aud_pkt_en,
   input  logic [GEN_N-1:0] gen_pkt_en,
   output logic             enc_clk_en,
   output logic             enc_rst,
   output logic             enc_en,
   output logic [SRC_W-1:0] pix_sel,
   output logic             vid_en,
   output logic             pfifo_rst,
   output logic             pfifo_en,
   output logic             cfifo_rst,
   output logic             cfifo_en,
   output logic             crc_en,
   output logic             sdp_en,
   output logic             busy,
   output logic             done,
   output logic             seq_err
);
   localparam int CYC_PER_US = CLK_HZ / 1_000_000;
   localparam int SHORT_DIV  = CYC_PER_US * SHORT_US;
   localparam int LONG_DIV   = CYC_PER_US * LONG_US;

   if (CYC_PER_US < 1) begin : g_bad_clk
      $error("strm_enc_seq: CLK_HZ must be at least 1 MHz");
   end
   if (SRC_W < 1 || AUD_N < 1 || GEN_N < 1) begin : g_bad_width
      $error("strm_enc_seq: widths must be at least 1");
   end

   seq_t              seq_q;
   logic [STEP_W-1:0] step_q;
   logic [SRC_W-1:0]  src_q;
   op_t               op;
   logic              wait_lvl, is_wait, wait_met, long_w;
   logic              s_exp, l_exp, tmo, sdp_drop, any_cmd, val;
   seq_t              pick;

   assign op = seq_op(seq_q, step_q);

   always_comb begin
      case (op.src)
         WS_ENC:  wait_lvl = enc_rst_done;
         WS_PF:   wait_lvl = pfifo_rst_done;
         WS_CF:   wait_lvl = cfifo_rst_done;
         default: wait_lvl = vid_status;
      endcase
   end

   assign is_wait  = busy && (op.kind == OP_WAIT_HI || op.kind == OP_WAIT_LO);
   assign wait_met = (op.kind == OP_WAIT_HI) ? wait_lvl : !wait_lvl;
   assign long_w   = (op.src == WS_VID);
   assign tmo      = is_wait && !wait_met && (long_w ? l_exp : s_exp);
   assign sdp_drop = busy && op.kind == OP_CLR && op.tgt == TG_SDP;
   assign val      = (op.kind == OP_SET);

   strm_enc_poll_timer #(.DIV(SHORT_DIV), .POLLS(SHORT_POLLS)) u_short_tmr (
      .clk(clk), .rst_n(rst_n), .run(is_wait && !long_w), .expired(s_exp));
   strm_enc_poll_timer #(.DIV(LONG_DIV), .POLLS(LONG_POLLS)) u_long_tmr (
      .clk(clk), .rst_n(rst_n), .run(is_wait && long_w), .expired(l_exp));
   strm_enc_sdp_track #(.AUD_N(AUD_N), .GEN_N(GEN_N)) u_sdp (
      .clk(clk), .rst_n(rst_n), .vid_on(vid_en), .drop(sdp_drop),
      .aud(aud_pkt_en), .gen(gen_pkt_en), .sdp(sdp_en));

   // Coincident commands: disable > blank > unblank > enable
   assign any_cmd = cmd_enable || cmd_unblank || cmd_blank || cmd_disable;
   always_comb begin
      if (cmd_disable)      pick = SEQ_DISABLE;
      else if (cmd_blank)   pick = SEQ_BLANK;
      else if (cmd_unblank) pick = SEQ_UNBLANK;
      else                  pick = SEQ_ENABLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_q      <= SEQ_ENABLE;
         step_q     <= '0;
         src_q      <= '0;
         busy       <= 1'b0;
         done       <= 1'b0;
         seq_err    <= 1'b0;
         enc_clk_en <= 1'b0;
         enc_rst    <= 1'b0;
         enc_en     <= 1'b0;
         pix_sel    <= '0;
         vid_en     <= 1'b0;
         pfifo_rst  <= 1'b0;
         pfifo_en   <= 1'b0;
         cfifo_rst  <= 1'b0;
         cfifo_en   <= 1'b0;
         crc_en     <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (any_cmd) begin
               busy   <= 1'b1;
               seq_q  <= pick;
               step_q <= '0;
               if (pick == SEQ_UNBLANK) src_q <= src_sel;
            end
         end else begin
            case (op.kind)
               OP_SET, OP_CLR: begin
                  case (op.tgt)
                     TG_CLK:     enc_clk_en <= val;
                     TG_ENC_RST: enc_rst    <= val;
                     TG_ENC_EN:  enc_en     <= val;
                     TG_MUX:     pix_sel    <= val ? src_q : '0;
                     TG_VID:     vid_en     <= val;
                     TG_PF_RST:  pfifo_rst  <= val;
                     TG_PF_EN:   pfifo_en   <= val;
                     TG_CF_RST:  cfifo_rst  <= val;
                     TG_CF_EN:   cfifo_en   <= val;
                     TG_CRC:     crc_en     <= val;
                     default:    ;
                  endcase
                  step_q <= step_q + STEP_W'(1);
               end
               OP_WAIT_HI, OP_WAIT_LO: begin
                  if (wait_met) begin
                     step_q <= step_q + STEP_W'(1);
                  end else if (tmo) begin
                     busy    <= 1'b0;
                     seq_err <= 1'b1;
                  end
               end
               default: begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/strm_enc_seq_chk.sv
module strm_enc_seq_chk #(
   parameter int AUD_N = 4,
   parameter int GEN_N = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_any,
   input logic [AUD_N-1:0] aud_pkt_en,
   input logic [GEN_N-1:0] gen_pkt_en,
   input logic             enc_clk_en,
   input logic             enc_rst,
   input logic             enc_en,
   input logic             vid_en,
   input logic             pfifo_rst,
   input logic             pfifo_en,
   input logic             cfifo_rst,
   input logic             cfifo_en,
   input logic             crc_en,
   input logic             sdp_en,
   input logic             busy,
   input logic             done,
   input logic             seq_err
);
   // R2
   enc_en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(enc_en) |-> enc_clk_en && !enc_rst);
   // R3
   pf_en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pfifo_en) |-> vid_en && !pfifo_rst);
   // R3
   cf_en_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfifo_en) |-> pfifo_en && crc_en && !cfifo_rst);
   // R4
   pf_off_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pfifo_en) |-> !vid_en && !sdp_en);
   // R4
   cf_off_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cfifo_en) |-> !pfifo_en);
   // R5
   clk_off_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(enc_clk_en) |-> !enc_en);
   // R8
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cmd_any));
   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R6
   err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seq_err) |-> !busy && !done);
   // R12
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_err |=> seq_err);
   // R10
   sdp_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdp_en) |-> $past(vid_en) && ($past(|aud_pkt_en) || $past(|gen_pkt_en)));
   // R10
   sdp_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sdp_en) |-> !$past(vid_en) || (!$past(|aud_pkt_en) && !$past(|gen_pkt_en)));
endmodule

bind strm_enc_seq strm_enc_seq_chk #(.AUD_N(AUD_N), .GEN_N(GEN_N)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .cmd_any(cmd_enable || cmd_unblank || cmd_blank || cmd_disable),
   .aud_pkt_en(aud_pkt_en), .gen_pkt_en(gen_pkt_en),
   .enc_clk_en(enc_clk_en), .enc_rst(enc_rst), .enc_en(enc_en), .vid_en(vid_en),
   .pfifo_rst(pfifo_rst), .pfifo_en(pfifo_en), .cfifo_rst(cfifo_rst),
   .cfifo_en(cfifo_en), .crc_en(crc_en), .sdp_en(sdp_en),
   .busy(busy), .done(done), .seq_err(seq_err));

// File: tb/tb_strm_enc_seq.sv
`timescale 1ns/1ps
module tb_strm_enc_seq;
   localparam int CLK_HZ = 10_000_000, SHORT_US = 1, SHORT_POLLS = 10;
   localparam int LONG_US = 10, LONG_POLLS = 20, SRC_W = 2, AUD_N = 4, GEN_N = 4;
   // snapshot bit positions
   localparam int B_SDP = 0, B_CRC = 1, B_CFE = 2, B_CFR = 3, B_PFE = 4, B_PFR = 5;
   localparam int B_VID = 6, B_EN = 9, B_RST = 10, B_CLK = 11;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n = 1'b0;
   logic cmd_enable = 0, cmd_unblank = 0, cmd_blank = 0, cmd_disable = 0;
   logic [SRC_W-1:0] src_sel = '0;
   logic enc_rst_done, pfifo_rst_done, cfifo_rst_done;
   logic vid_status = 1'b0;
   logic [AUD_N-1:0] aud_pkt_en = '0;
   logic [GEN_N-1:0] gen_pkt_en = '0;
   logic enc_clk_en, enc_rst, enc_en, vid_en, pfifo_rst, pfifo_en, cfifo_rst, cfifo_en;
   logic crc_en, sdp_en, busy, done, seq_err;
   logic [SRC_W-1:0] pix_sel;

   strm_enc_seq #(.CLK_HZ(CLK_HZ), .SHORT_US(SHORT_US), .SHORT_POLLS(SHORT_POLLS),
                  .LONG_US(LONG_US), .LONG_POLLS(LONG_POLLS), .SRC_W(SRC_W),
                  .AUD_N(AUD_N), .GEN_N(GEN_N)) dut (.*);

   // reset-done echo models with a stuck control
   logic [2:0] enc_pipe = '0, pf_pipe = '0, cf_pipe = '0;
   logic enc_stuck = 1'b0;
   always @(posedge clk) begin
      enc_pipe <= {enc_pipe[1:0], enc_rst};
      pf_pipe  <= {pf_pipe[1:0], pfifo_rst};
      cf_pipe  <= {cf_pipe[1:0], cfifo_rst};
   end
   assign enc_rst_done   = enc_pipe[2] && !enc_stuck;
   assign pfifo_rst_done = pf_pipe[2];
   assign cfifo_rst_done = cf_pipe[2];

   int n_cmp = 0, n_bad = 0, cyc = 0, vs_fall = 0;
   always @(posedge clk) cyc <= cyc + 1;

   logic [11:0] snap, prev_snap = '0;
   assign snap = {enc_clk_en, enc_rst, enc_en, pix_sel, vid_en, pfifo_rst, pfifo_en,
                  cfifo_rst, cfifo_en, crc_en, sdp_en};
   int rise_at[12], fall_at[12];
   always @(negedge clk) begin
      for (int i = 0; i < 12; i++) begin
         if (snap[i] && !prev_snap[i]) rise_at[i] = cyc;
         if (!snap[i] && prev_snap[i]) fall_at[i] = cyc;
      end
      prev_snap = snap;
   end

   function automatic logic [11:0] mk(bit c, bit r, bit e, logic [1:0] m, bit v, bit pr,
                                      bit pe, bit cr, bit ce, bit cc, bit s);
      return {c, r, e, m, v, pr, pe, cr, ce, cc, s};
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // scoreboard
   logic [11:0] exp_q[$];
   string       tag_q[$];
   task automatic expect_seq(string tag, logic [11:0] e);
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   always @(negedge clk) begin
      logic [11:0] e;
      string t;
      if (rst_n && done) begin
         if (exp_q.size() == 0) check("R8", 32'd1, 32'd0, "unexpected done pulse");
         else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, 32'(snap), 32'(e), "outputs at done");
         end
      end
   end

   task automatic drive_cmd(logic [3:0] m, logic [1:0] src);
      @(posedge clk); #1;
      {cmd_disable, cmd_blank, cmd_unblank, cmd_enable} = m;
      src_sel = src;
      @(posedge clk); #1;
      {cmd_disable, cmd_blank, cmd_unblank, cmd_enable} = '0;
      @(negedge clk);
   endtask

   task automatic issue(logic [3:0] m, logic [1:0] src);
      drive_cmd(m, src);
      check("R9", 32'(busy), 32'd1, "busy after accepted command");
   endtask

   task automatic wait_idle(int lim);
      int k = 0;
      while (busy && k < lim) begin @(negedge clk); k++; end
      check("R9", 32'(busy), 32'd0, "sequence finished");
      @(negedge clk);
      check("R9", 32'(exp_q.size()), 32'd0, "expected done consumed");
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check("R1", 32'(snap), 32'd0, "outputs after reset");
      check("R1", 32'({busy, done, seq_err}), 32'd0, "status after reset");
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL R9 watchdog: busy=%0b expected=0 within cycle limit", busy);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      do_reset();

      // R2 enable
      expect_seq("R2", mk(1,0,1,2'd0,0,0,0,0,0,0,0));
      issue(4'b0001, 2'd0);
      wait_idle(200);
      check("R2", 32'(rise_at[B_CLK] < rise_at[B_RST] && rise_at[B_RST] < fall_at[B_RST]
                      && fall_at[B_RST] < rise_at[B_EN]), 32'd1, "enable step order");

      // R3 unblank, source 2
      expect_seq("R3", mk(1,0,1,2'd2,1,0,1,0,1,1,0));
      issue(4'b0010, 2'd2);
      wait_idle(300);
      check("R3", 32'(rise_at[B_VID] < rise_at[B_PFR] && rise_at[B_PFR] < fall_at[B_PFR]
                      && fall_at[B_PFR] < rise_at[B_PFE]), 32'd1, "pixel FIFO handshake order");
      check("R3", 32'(rise_at[B_PFE] < rise_at[B_CFR] && rise_at[B_CFR] < fall_at[B_CFR]
                      && fall_at[B_CFR] < rise_at[B_CRC] && rise_at[B_CRC] < rise_at[B_CFE]),
            32'd1, "clock-ramp FIFO order");

      // R10 secondary data tracking
      aud_pkt_en = 4'b0010;
      repeat (2) @(negedge clk);
      check("R10", 32'(sdp_en), 32'd1, "sdp on with audio");
      aud_pkt_en = '0;
      repeat (2) @(negedge clk);
      check("R10", 32'(sdp_en), 32'd0, "sdp off with no packets");
      gen_pkt_en = 4'b1000;
      repeat (2) @(negedge clk);
      check("R10", 32'(sdp_en), 32'd1, "sdp on with generic packet");

      // R4 blank with status held, R8 disable during busy
      vid_status = 1'b1;
      expect_seq("R4", mk(1,0,1,2'd2,0,0,0,0,0,1,0));
      issue(4'b0100, 2'd0);
      repeat (10) @(negedge clk);
      drive_cmd(4'b1000, 2'd0);
      repeat (20) @(negedge clk);
      check("R4", 32'({busy, pfifo_en, sdp_en}), 32'b111, "holding while status high");
      @(posedge clk); #1 vid_status = 1'b0; vs_fall = cyc;
      @(negedge clk);
      wait_idle(100);
      check("R4", 32'(fall_at[B_VID] < vs_fall && fall_at[B_SDP] > vs_fall), 32'd1,
            "sdp cleared after status low");
      check("R4", 32'(fall_at[B_PFE] == fall_at[B_SDP] + 1 && fall_at[B_CFE] == fall_at[B_PFE] + 1),
            32'd1, "sdp, pixel, clock-ramp clear order");
      repeat (5) @(negedge clk);
      check("R8", 32'({enc_clk_en, enc_en}), 32'b11, "disable while busy ignored");
      check("R10", 32'(sdp_en), 32'd0, "sdp stays off with video off");
      gen_pkt_en = '0;

      // R11 coincident enable + disable: disable wins
      expect_seq("R11", mk(0,0,0,2'd2,0,0,0,0,0,1,0));
      issue(4'b1001, 2'd0);
      wait_idle(50);
      check("R5", 32'(fall_at[B_CLK] == fall_at[B_EN] + 1), 32'd1, "clock off one cycle after encoder");

      // R6 short timeout
      enc_stuck = 1'b1;
      issue(4'b0001, 2'd0);
      repeat (80) @(negedge clk);
      check("R6", 32'({busy, seq_err}), 32'b10, "still waiting before budget");
      repeat (40) @(negedge clk);
      check("R6", 32'({busy, seq_err}), 32'b01, "aborted after budget");
      check("R6", 32'({enc_clk_en, enc_rst, enc_en}), 32'b110, "outputs frozen at abort");

      // R12 error sticky, later command runs
      enc_stuck = 1'b0;
      repeat (5) @(negedge clk);
      expect_seq("R12", mk(1,0,1,2'd2,0,0,0,0,0,1,0));
      issue(4'b0001, 2'd0);
      wait_idle(200);
      check("R12", 32'(seq_err), 32'd1, "error flag stays set");

      // R7 long timeout after a fresh reset
      do_reset();
      expect_seq("R2", mk(1,0,1,2'd0,0,0,0,0,0,0,0));
      issue(4'b0001, 2'd0);
      wait_idle(200);
      expect_seq("R3", mk(1,0,1,2'd1,1,0,1,0,1,1,0));
      issue(4'b0010, 2'd1);
      wait_idle(300);
      vid_status = 1'b1;
      issue(4'b0100, 2'd0);
      repeat (1900) @(negedge clk);
      check("R7", 32'({busy, seq_err}), 32'b10, "still waiting for vertical blank");
      repeat (200) @(negedge clk);
      check("R7", 32'({busy, seq_err}), 32'b01, "blank wait aborted");
      check("R7", 32'({vid_en, pfifo_en, cfifo_en}), 32'b011, "FIFO enables left as they were");
      vid_status = 1'b0;

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule